// File: doc/BRIEF.md
# Serial Board Configuration Loader

This block takes configuration bytes from a host command port and shifts them out one bit at a time on a single serial data line, together with a shift clock. Once a byte has been shifted, the block pulses the strobe of the chosen remote board. That board then copies the bits it has collected into its holding latches. One serial channel therefore serves five load targets: the output amplifier, the first loop board, two latches on the second loop board, and the sine shaper.

A status command works the other way. It first pulses a dedicated status strobe, which makes the second loop board capture its status into its shift register. The block then releases the data line, clocks the status back in, and hands it to the host as a parallel byte.

A third command drives an active-low trigger to an external magnetic-latch strobe generator. The trigger stays low until that generator reports that its strobe has ended. Releasing the trigger any earlier would cut the strobe short, so a timeout is the only other way the trigger is released.

Top module: `cfg_serial_loader`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `strobe`, `sclk`, `sdata_oe`, `rd_valid` and `trig_err` are 0, and `trig_n` is 1.
- R2: A load command is `cmd_op`=0 with `cmd_target` 0 to 4. It shifts `cmd_data` out on `sdata_out` with `sdata_oe` high, most significant bit first. Each shift-clock period is 2*HALF system cycles: low for HALF cycles, then high for HALF cycles. Each bit is stable on the rising edge of `sclk`, and `sclk` is high for exactly 8*HALF cycles per byte.
- R3: After the eighth bit of a load, only `strobe[cmd_target]` goes high, for one shift-clock period (2*HALF cycles), and it goes high exactly once. The strobe bits are: 0 output amplifier, 1 first loop board, 2 and 3 the two second-loop latches, 4 sine shaper.
- R4: A status command is `cmd_op`=1. It pulses `strobe[5]` for one shift-clock period with `sdata_oe` low. It then runs eight shift-clock periods with `sdata_oe` low, sampling `sdata_in` at the end of each high phase, most significant bit first.
- R5: When a status read completes, the eight sampled bits appear on `rd_data` together with a one-cycle `rd_valid` pulse. `rd_data` then holds its value until the next status read completes.
- R6: A trigger command is `cmd_op`=2. It drives `trig_n` low from the cycle after acceptance. `trig_n` stays low until a rising edge of `eos_in` has passed the two-stage synchronizer, and returns high no more than four cycles after that edge.
- R7: If no rising edge of `eos_in` arrives within TMO cycles of a trigger, `trig_n` returns high and `trig_err` is set. `trig_err` stays set through other commands and is cleared only when the next trigger command is accepted.
- R8: `busy` is high from the cycle after a command is accepted until its operation ends. A command presented while `busy` is high has no effect.
- R9: A command with `cmd_op`=3, or with `cmd_op`=0 and `cmd_target` 5 to 7, is not accepted. `busy` stays low and no strobe pulses.
- R10: At most one strobe bit is high at any time, and no strobe is high while `trig_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 load, 1 status read, 2 latch trigger, 3 unused |
| cmd_target | input | 3 | Load target strobe index (0 to 4) |
| cmd_data | input | 8 | Byte to shift out on a load |
| busy | output | 1 | Operation in progress |
| rd_data | output | 8 | Last status byte read back |
| rd_valid | output | 1 | One-cycle pulse when rd_data is updated |
| sdata_out | output | 1 | Serial data driven toward the boards |
| sdata_oe | output | 1 | High while the block drives the shared data line |
| sdata_in | input | 1 | Serial data returned from the boards |
| sclk | output | 1 | Shift clock |
| strobe | output | 6 | Board load strobes 0 to 4, status strobe 5 |
| trig_n | output | 1 | Active-low magnetic-latch trigger |
| eos_in | input | 1 | End-of-strobe return, asynchronous |
| trig_err | output | 1 | Sticky flag: trigger released by timeout |

## Verification
The properties assume the host only presents `cmd_op` and `cmd_target` values that are defined while `cmd_valid` is high. They also assume `eos_in` is a level that may change at any time, so the checks only look at the released trigger and never at the synchronizer timing. The bench drives every input on the falling clock edge. It moves `sdata_in` only from its remote-board model, on falling `sclk`, which keeps each returned bit stable through the sampling cycle. It asserts `eos_in` only while a trigger is pending, or on purpose with no trigger pending.

// File: rtl/cfgld_pkg.sv
// Package: shared opcodes, sequencer states and strobe layout for the
// serial configuration loader. Assumes at most eight strobe indices.
package cfgld_pkg;
    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STATUS = 2'd1,
        OP_TRIG   = 2'd2,
        OP_NONE   = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_SHIFT  = 3'd1,
        S_STRB   = 3'd2,
        S_RSTB   = 3'd3,
        S_RSHIFT = 3'd4
    } sh_state_e;

    localparam int NUM_TGT  = 5;   // load targets
    localparam int NUM_STRB = 6;   // load targets plus status strobe
    localparam int STAT_IDX = 5;   // status strobe index
endpackage

// File: rtl/cfgld_edge_sync.sv
// Module: synchronizes an asynchronous level through STAGES flops and
// flags one cycle when the synchronized level rises.
// Assumes: STAGES >= 2; the input may change at any time.
module cfgld_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    // shift the input through the synchronizer and keep one delayed copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            last  <= chain[STAGES-1];
        end
    end

    // flag a low-to-high transition of the synchronized level
    always_comb rise = chain[STAGES-1] && !last;
endmodule

// File: rtl/cfgld_trig.sv
// Module: holds the active-low latch trigger from the start pulse until a
// synchronized end-of-strobe edge, or until TMO cycles pass (sticky error).
// Assumes: start is only pulsed while the trigger is inactive.
module cfgld_trig #(
    parameter int TMO = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic eos_in,
    output logic trig_n,
    output logic active,
    output logic err
);
    localparam int CW = $clog2(TMO + 1);

    logic [CW-1:0] cnt;
    logic          eos_rise;

    cfgld_edge_sync #(.STAGES(2)) u_eos (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (eos_in),
        .rise     (eos_rise)
    );

    // trigger hold, timeout count and sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            err    <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            err    <= 1'b0;
        end else if (active) begin
            if (eos_rise) begin
                active <= 1'b0;
            end else if (cnt == CW'(TMO - 1)) begin
                active <= 1'b0;
                err    <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // trigger output is the inverse of the hold state
    always_comb trig_n = !active;
endmodule

// File: rtl/cfgld_shifter.sv
// Module: serial engine. A load shifts a byte out MSB first and then
// pulses the target strobe for one shift period. A status read pulses the
// status strobe and then shifts a byte in, sampling at the end of each high
// phase. Assumes: starts arrive only while idle; target < NUM_TGT.
module cfgld_shifter
    import cfgld_pkg::*;
#(
    parameter int W    = 8,
    parameter int HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_load,
    input  logic                start_stat,
    input  logic [2:0]          tgt_in,
    input  logic [W-1:0]        data_in,
    input  logic                ser_in,
    output logic                ser_out,
    output logic                ser_oe,
    output logic                sclk,
    output logic [NUM_STRB-1:0] strobe,
    output logic [W-1:0]        rd_data,
    output logic                rd_valid,
    output logic                busy
);
    localparam int PER = 2 * HALF;
    localparam int PW  = (PER > 1) ? $clog2(PER) : 1;
    localparam int BW  = (W > 1) ? $clog2(W) : 1;

    sh_state_e      state;
    logic [PW-1:0]  ph;
    logic [BW-1:0]  bitn;
    logic [W-1:0]   sreg;
    logic [2:0]     tgt;
    logic           ph_end;

    // last cycle of the current shift-clock period
    always_comb ph_end = (ph == PW'(PER - 1));

    // sequencer: phase counter, bit counter, shift register, read result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            ph       <= '0;
            bitn     <= '0;
            sreg     <= '0;
            tgt      <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (state == S_IDLE) begin
                ph   <= '0;
                bitn <= '0;
                if (start_load) begin
                    sreg  <= data_in;
                    tgt   <= tgt_in;
                    state <= S_SHIFT;
                end else if (start_stat) begin
                    state <= S_RSTB;
                end
            end else begin
                ph <= ph_end ? '0 : ph + 1'b1;
                if (ph_end) begin
                    unique case (state)
                        S_SHIFT: begin
                            sreg <= {sreg[W-2:0], 1'b0};
                            if (bitn == BW'(W - 1)) state <= S_STRB;
                            else                    bitn  <= bitn + 1'b1;
                        end
                        S_STRB: state <= S_IDLE;
                        S_RSTB: state <= S_RSHIFT;
                        S_RSHIFT: begin
                            sreg <= {sreg[W-2:0], ser_in};
                            if (bitn == BW'(W - 1)) begin
                                rd_data  <= {sreg[W-2:0], ser_in};
                                rd_valid <= 1'b1;
                                state    <= S_IDLE;
                            end else begin
                                bitn <= bitn + 1'b1;
                            end
                        end
                        default: state <= S_IDLE;
                    endcase
                end
            end
        end
    end

    // line outputs: data, drive enable and shift clock
    always_comb begin
        ser_out = (state == S_SHIFT) && sreg[W-1];
        ser_oe  = (state == S_SHIFT);
        sclk    = ((state == S_SHIFT) || (state == S_RSHIFT)) && (ph >= PW'(HALF));
        busy    = (state != S_IDLE);
    end

    // one load strobe per target, decoded from the latched target
    for (genvar i = 0; i < NUM_TGT; i++) begin : g_ld_strb
        assign strobe[i] = (state == S_STRB) && (tgt == 3'(i));
    end
    assign strobe[STAT_IDX] = (state == S_RSTB);
endmodule

// File: rtl/cfg_serial_loader.sv
// Module: top of the serial configuration loader. Accepts one host command
// at a time, routes loads and status reads to the serial engine and trigger
// commands to the latch-trigger handshake. Illegal commands and commands
// arriving while busy are dropped. Assumes: eos_in may be asynchronous.
module cfg_serial_loader
    import cfgld_pkg::*;
#(
    parameter int W    = 8,
    parameter int HALF = 2,
    parameter int TMO  = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [2:0]          cmd_target,
    input  logic [W-1:0]        cmd_data,
    output logic                busy,
    output logic [W-1:0]        rd_data,
    output logic                rd_valid,
    output logic                sdata_out,
    output logic                sdata_oe,
    input  logic                sdata_in,
    output logic                sclk,
    output logic [NUM_STRB-1:0] strobe,
    output logic                trig_n,
    input  logic                eos_in,
    output logic                trig_err
);
    logic sh_busy;
    logic tr_active;
    logic go_load;
    logic go_stat;
    logic go_trig;

    // command acceptance: idle and a legal opcode/target
    always_comb begin
        busy    = sh_busy || tr_active;
        go_load = cmd_valid && !busy && (cmd_op == OP_LOAD)
                  && (cmd_target < 3'(NUM_TGT));
        go_stat = cmd_valid && !busy && (cmd_op == OP_STATUS);
        go_trig = cmd_valid && !busy && (cmd_op == OP_TRIG);
    end

    cfgld_shifter #(.W(W), .HALF(HALF)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_load (go_load),
        .start_stat (go_stat),
        .tgt_in     (cmd_target),
        .data_in    (cmd_data),
        .ser_in     (sdata_in),
        .ser_out    (sdata_out),
        .ser_oe     (sdata_oe),
        .sclk       (sclk),
        .strobe     (strobe),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .busy       (sh_busy)
    );

    cfgld_trig #(.TMO(TMO)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (go_trig),
        .eos_in (eos_in),
        .trig_n (trig_n),
        .active (tr_active),
        .err    (trig_err)
    );
endmodule

// File: rtl/cfgld_checker.sv
// Module: property checker for the serial configuration loader, bound to
// the top module. Observes ports only.
module cfgld_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic [2:0] cmd_target,
    input logic       busy,
    input logic       rd_valid,
    input logic       sdata_oe,
    input logic       sclk,
    input logic [5:0] strobe,
    input logic       trig_n,
    input logic       trig_err
);
    // R10
    strb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe));

    // R10
    strb_trig_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_n |-> (strobe == 6'd0));

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 2'd0 && cmd_target < 3'd5) |=> busy);

    // R9
    illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 2'd3) |=> !busy);

    // R5
    rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !sdata_oe));

    // R4
    strb_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe != 6'd0) |-> !sdata_oe);

    // R7
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_err) |-> $past(!trig_n));
endmodule

bind cfg_serial_loader cfgld_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_target (cmd_target),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .sdata_oe   (sdata_oe),
    .sclk       (sclk),
    .strobe     (strobe),
    .trig_n     (trig_n),
    .trig_err   (trig_err)
);

// File: tb/cfg_serial_loader_bench.sv
// Bench: remote-board model plus a vector table of loads and status reads,
// then directed tests for reset, triggers, timeout and dropped commands.
module cfg_serial_loader_bench;
    localparam int HALF = 2;
    localparam int PER  = 2 * HALF;
    localparam int TMO  = 4096;
    localparam int WD   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [2:0] cmd_target = 3'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       busy;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       sdata_out;
    logic       sdata_oe;
    logic       sdata_in = 1'b0;
    logic       sclk;
    logic [5:0] strobe;
    logic       trig_n;
    logic       eos_in = 1'b0;
    logic       trig_err;

    cfg_serial_loader #(.W(8), .HALF(HALF), .TMO(TMO)) u_cfg_serial_loader (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_target(cmd_target), .cmd_data(cmd_data), .busy(busy),
        .rd_data(rd_data), .rd_valid(rd_valid), .sdata_out(sdata_out),
        .sdata_oe(sdata_oe), .sdata_in(sdata_in), .sclk(sclk),
        .strobe(strobe), .trig_n(trig_n), .eos_in(eos_in), .trig_err(trig_err)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit fin   = 1'b0;

    // remote board model: receive shift register, latches, strobe counters
    logic [7:0] rx_sh = 8'd0;
    logic [7:0] latch [0:5];
    int         scnt  [0:5];
    logic [5:0] prev_strb = 6'd0;
    int         strb_w = 0;
    int         sclk_hi = 0;
    int         rdv_cnt = 0;
    logic [7:0] stat_val = 8'd0;
    logic [7:0] stat_sh = 8'd0;

    initial for (int i = 0; i < 6; i++) begin latch[i] = 8'd0; scnt[i] = 0; end

    always @(posedge sclk) if (sdata_oe) rx_sh <= {rx_sh[6:0], sdata_out};

    always @(negedge clk) begin
        for (int i = 0; i < 6; i++) begin
            if (strobe[i] && !prev_strb[i]) begin
                scnt[i]  <= scnt[i] + 1;
                latch[i] <= rx_sh;
            end
        end
        prev_strb <= strobe;
        if (|strobe) strb_w <= strb_w + 1;
        if (sclk) sclk_hi <= sclk_hi + 1;
    end

    always @(posedge clk) if (rd_valid) rdv_cnt <= rdv_cnt + 1;

    always @(posedge strobe[5]) begin
        stat_sh  <= stat_val;
        sdata_in <= stat_val[7];
    end

    always @(negedge sclk) if (!sdata_oe) begin
        stat_sh  <= {stat_sh[6:0], 1'b0};
        sdata_in <= stat_sh[6];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [2:0] t, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_target = t; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 3000 && busy; n++) @(negedge clk);
    endtask

    // vectors: {op, target, load data, status returned by the board}
    localparam logic [20:0] VEC [0:7] = '{
        {2'd0, 3'd0, 8'hA5, 8'h00},
        {2'd0, 3'd1, 8'h3C, 8'h00},
        {2'd0, 3'd2, 8'h80, 8'h00},
        {2'd0, 3'd3, 8'h01, 8'h00},
        {2'd0, 3'd4, 8'hFF, 8'h00},
        {2'd1, 3'd0, 8'h00, 8'h5A},
        {2'd1, 3'd0, 8'h00, 8'hC3},
        {2'd0, 3'd2, 8'h6E, 8'h00}
    };

    initial begin
        repeat (WD) @(posedge clk);
        if (!fin) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(!busy && strobe == 0 && !sclk && !sdata_oe && trig_n && !trig_err && !rd_valid,
            "R1 in reset", {busy, strobe, sclk, sdata_oe, trig_n, trig_err}, 32'h2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && strobe == 0 && trig_n && !trig_err, "R1 after reset",
            {busy, strobe, trig_n, trig_err}, 32'h2);

        for (int v = 0; v < 8; v++) begin
            logic [1:0] op; logic [2:0] t; logic [7:0] d; logic [7:0] s;
            int c0 [0:5]; int w0; int h0; int r0;
            {op, t, d, s} = VEC[v];
            stat_val = s;
            for (int i = 0; i < 6; i++) c0[i] = scnt[i];
            w0 = strb_w; h0 = sclk_hi; r0 = rdv_cnt;
            issue(op, t, d);
            chk(busy, "R8 busy after accept", busy, 1);
            wait_idle();
            @(negedge clk);
            chk(strb_w - w0 == PER, "R3/R4 strobe width", strb_w - w0, PER);
            if (op == 2'd0) begin
                chk(latch[t] == d, "R2 data shifted MSB first", latch[t], d);
                chk(sclk_hi - h0 == 8 * HALF, "R2 shift clock high time", sclk_hi - h0, 8 * HALF);
                for (int i = 0; i < 6; i++)
                    chk(scnt[i] - c0[i] == ((i == t) ? 1 : 0), "R3 strobe select",
                        scnt[i] - c0[i], (i == t) ? 1 : 0);
            end else begin
                chk(rd_data == s, "R4 status read back", rd_data, s);
                chk(rdv_cnt - r0 == 1, "R5 rd_valid pulse", rdv_cnt - r0, 1);
                chk(scnt[5] - c0[5] == 1, "R4 status strobe", scnt[5] - c0[5], 1);
                chk(sclk_hi - h0 == 8 * HALF, "R4 shift clock high time", sclk_hi - h0, 8 * HALF);
            end
        end

        // R8: command while busy is dropped
        begin
            int c2;
            c2 = scnt[2];
            issue(2'd0, 3'd1, 8'h9B);
            repeat (3) @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 2'd0; cmd_target = 3'd2; cmd_data = 8'h11;
            @(negedge clk);
            cmd_valid = 1'b0;
            wait_idle();
            repeat (10) @(negedge clk);
            chk(latch[1] == 8'h9B, "R8 first load intact", latch[1], 8'h9B);
            chk(scnt[2] == c2, "R8 busy command dropped", scnt[2], c2);
        end

        // R9: illegal target and opcode are not accepted; R5 rd_data holds
        begin
            int c5; int cs;
            c5 = scnt[5]; cs = scnt[0] + scnt[1] + scnt[2] + scnt[3] + scnt[4];
            issue(2'd0, 3'd6, 8'h77);
            chk(!busy, "R9 target 6 ignored", busy, 0);
            issue(2'd3, 3'd0, 8'h77);
            chk(!busy, "R9 opcode 3 ignored", busy, 0);
            repeat (20) @(negedge clk);
            chk(scnt[0] + scnt[1] + scnt[2] + scnt[3] + scnt[4] + scnt[5] == cs + c5,
                "R9 no strobe", scnt[0] + scnt[1] + scnt[2] + scnt[3] + scnt[4] + scnt[5], cs + c5);
            chk(rd_data == 8'hC3, "R5 rd_data held", rd_data, 8'hC3);
        end

        // R6: trigger held until end-of-strobe
        issue(2'd2, 3'd0, 8'h00);
        chk(!trig_n && busy, "R6 trigger asserted", {trig_n, busy}, 1);
        repeat (20) @(negedge clk);
        chk(!trig_n, "R6 trigger held", trig_n, 0);
        eos_in = 1'b1;
        repeat (4) @(negedge clk);
        chk(trig_n && !trig_err && !busy, "R6 trigger released", {trig_n, trig_err, busy}, 4);
        eos_in = 1'b0;
        repeat (4) @(negedge clk);

        // R7: timeout
        issue(2'd2, 3'd0, 8'h00);
        repeat (TMO - 20) @(negedge clk);
        chk(!trig_n && !trig_err, "R7 before timeout", {trig_n, trig_err}, 0);
        repeat (30) @(negedge clk);
        chk(trig_n && trig_err, "R7 timeout release", {trig_n, trig_err}, 3);
        issue(2'd0, 3'd4, 8'h42);
        wait_idle();
        chk(trig_err, "R7 error sticky", trig_err, 1);
        issue(2'd2, 3'd0, 8'h00);
        chk(!trig_err && !trig_n, "R7 error cleared", {trig_n, trig_err}, 0);
        @(negedge clk);
        eos_in = 1'b1;
        repeat (5) @(negedge clk);
        chk(trig_n, "R10 trigger finished", trig_n, 1);

        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule